// File: doc/BRIEF.md
# Four-Beat Burst Word Address Sequencer

This block produces the word address for a short burst access into a synchronous memory. A start strobe captures an external base address and an order select. After that, each advance pulse steps the two least significant address bits through four beats, while the upper bits stay fixed. The two low bits follow one of two orders. In linear order they increment modulo four from the start value. In interleaved order each beat index is XORed with the start value. After four advances the address is back at the captured base, and the burst can continue around the same four words.

Cycles with neither a start nor an advance leave the address unchanged. Bursts do not have to run to their end: a new start may be issued in any cycle, including the cycle right after the previous one. Before the first start after reset the sequencer is idle and drives an all-zero address.

The control is a small state machine. Its states are `ST_IDLE` (no burst captured yet) and `ST_BEAT0`, `ST_BEAT1`, `ST_BEAT2` and `ST_BEAT3`, where the number is the beat index n. The transitions are:
- **start**: from any state to `ST_BEAT0` when `load_i` is high.
- **step**: from `ST_BEATn` to `ST_BEAT(n+1)` on `adv_i`.
- **wrap**: from `ST_BEAT3` to `ST_BEAT0` on `adv_i`.
- **stay**: remain in the current state otherwise. This covers `ST_IDLE` when `adv_i` is high.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until the first start, `addr_o` is all zeros.
- R2: A cycle with `load_i` high makes `addr_o` equal to `base_addr_i` right after that clock edge.
- R3: When `load_i` and `adv_i` are both high in the same cycle, the start wins: `addr_o` becomes the base, not the base plus one beat.
- R4: A cycle with both `load_i` and `adv_i` low leaves `addr_o` unchanged.
- R5: With linear order (`order_lin_i` = 1 at the start), beat n has low bits equal to (start + n) mod 4, for example 1,2,3,0.
- R6: With interleaved order (`order_lin_i` = 0 at the start), beat n has low bits equal to start XOR n, for example 1,0,3,2.
- R7: The fourth advance after a start brings `addr_o` back to the captured base.
- R8: Between starts, the upper bits `addr_o[ADDR_W-1:2]` never change, and `base_addr_i` has no effect.
- R9: `order_lin_i` is captured only on a start. Changing it in the middle of a burst has no effect on the sequence.
- R10: An `order_lin_i` held low, which is the reset level, selects interleaved order.
- R11: An advance while idle, before any start, has no effect: `addr_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start strobe: captures the base address and the order select |
| base_addr_i | input | ADDR_W | External word address used as the burst base |
| adv_i | input | 1 | Advance to the next beat |
| order_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_o | output | ADDR_W | Current word address |

## Verification
The assertions assume that every control input is a known, synchronous level at each rising edge. They also assume that `order_lin_i` matters only in the cycle that carries a start, since the stepping checks use the captured order and not the live pin. The bench keeps within these assumptions:
- It changes every input only at the falling clock edge.
- It holds reset until the inputs are at defined idle levels.
- It toggles the order pin in the middle of a burst only to show that the toggle is ignored.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    // Width of the beat counter; four beats per burst.
    parameter int unsigned BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } seq_state_t;
endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    output logic              active_o,
    output logic [BEAT_W-1:0] beat_o
);
    seq_state_t state_q;
    seq_state_t state_d;

    // Next-state selection: a start overrides an advance.
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_BEAT0;
        end else if (adv_i) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state.
    always_comb begin
        active_o = 1'b1;
        beat_o   = '0;
        unique case (state_q)
            ST_IDLE:  begin active_o = 1'b0; beat_o = BEAT_W'(0); end
            ST_BEAT0: beat_o = BEAT_W'(0);
            ST_BEAT1: beat_o = BEAT_W'(1);
            ST_BEAT2: beat_o = BEAT_W'(2);
            ST_BEAT3: beat_o = BEAT_W'(3);
            default:  begin active_o = 1'b0; beat_o = '0; end
        endcase
    end
endmodule

// File: rtl/burst_low_gen.sv
module burst_low_gen
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              linear_i,
    output logic [BEAT_W-1:0] low_o
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] xor_low;

    assign lin_low = start_i + beat_i;
    assign xor_low = start_i ^ beat_i;
    assign low_o   = linear_i ? lin_low : xor_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic              adv_i,
    input  logic              order_lin_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int unsigned HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic              order_q;
    logic              active;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;

    // Base and order are captured only on a start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= 1'b0;
        end else if (load_i) begin
            base_q  <= base_addr_i;
            order_q <= order_lin_i;
        end
    end

    burst_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .adv_i    (adv_i),
        .active_o (active),
        .beat_o   (beat)
    );

    burst_low_gen u_low (
        .start_i  (base_q[BEAT_W-1:0]),
        .beat_i   (beat),
        .linear_i (order_q),
        .low_o    (low)
    );

    assign addr_o = active ? {base_q[ADDR_W-1:BEAT_W], low}
                           : {HI_W'(0), BEAT_W'(0)};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic              adv_i,
    input logic              order_q,
    input logic              active,
    input logic [ADDR_W-1:0] addr_o
);
    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(base_addr_i));

    // R4
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(addr_o));

    // R8
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

    // R5
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && active && order_q)
            |=> addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1));

    // R6
    xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && active && !order_q)
            |=> addr_o[0] != $past(addr_o[0]));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> addr_o == '0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .base_addr_i (base_addr_i),
    .adv_i       (adv_i),
    .order_q     (order_q),
    .active      (active),
    .addr_o      (addr_o)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] base_addr_i = '0;
    logic         adv_i = 1'b0;
    logic         order_lin_i = 1'b0;
    logic [W-1:0] addr_o;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    logic [W-1:0] m_base = '0;
    logic         m_lin = 1'b0;
    int           m_n = 0;
    logic         m_act = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(W)) u_burst_addr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .base_addr_i (base_addr_i),
        .adv_i       (adv_i),
        .order_lin_i (order_lin_i),
        .addr_o      (addr_o)
    );

    function automatic logic [W-1:0] expect_addr();
        logic [1:0] lo;
        if (!m_act) return '0;
        lo = m_lin ? 2'(m_base[1:0] + 2'(m_n)) : (m_base[1:0] ^ 2'(m_n));
        return {m_base[W-1:2], lo};
    endfunction

    task automatic check(input logic [W-1:0] exp, input string req);
        checks++;
        if (addr_o !== exp) begin
            errors++;
            $display("FAIL %s: addr_o=%h expected %h", req, addr_o, exp);
        end
    endtask

    task automatic step(input logic ld, input logic [W-1:0] b, input logic adv,
                        input logic lin, input string req);
        @(negedge clk);
        load_i = ld; base_addr_i = b; adv_i = adv; order_lin_i = lin;
        @(posedge clk); #1;
        if (ld) begin
            m_base = b; m_lin = lin; m_n = 0; m_act = 1'b1;
        end else if (adv && m_act) begin
            m_n = (m_n + 1) % 4;
        end
        check(expect_addr(), req);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] base;
        logic [5:0]   uppers [2];
        uppers[0] = 6'h2A;
        uppers[1] = 6'h15;

        // R1: zero during reset
        repeat (3) @(posedge clk);
        #1 check('0, "R1");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check('0, "R1");
        // R11: advance while idle
        step(1'b0, 8'hFF, 1'b1, 1'b1, "R11");
        step(1'b0, 8'h5A, 1'b1, 1'b0, "R11");

        for (int lin = 0; lin < 2; lin++) begin
            for (int u = 0; u < 2; u++) begin
                for (int s = 0; s < 4; s++) begin
                    base = {uppers[u], 2'(s)};
                    // R2 / R3: start, with a competing advance on odd starts
                    step(1'b1, base, s[0], lin[0], s[0] ? "R3" : "R2");
                    // R4: hold, base input changed (R8)
                    step(1'b0, ~base, 1'b0, lin[0], "R4");
                    for (int k = 1; k < 4; k++) begin
                        if (k == 2)
                            step(1'b0, ~base, 1'b1, ~lin[0], "R9");
                        else
                            step(1'b0, ~base, 1'b1, lin[0], lin[0] ? "R5" : "R6");
                    end
                    // R7: fourth advance returns to the base
                    step(1'b0, ~base, 1'b1, lin[0], "R7");
                    step(1'b0, 8'h00, 1'b0, lin[0], "R8");
                end
            end
        end

        // R10: order pin at its low level gives interleaved 1,0,3,2
        step(1'b1, 8'h41, 1'b0, 1'b0, "R10");
        step(1'b0, 8'h00, 1'b1, 1'b0, "R10");
        if (addr_o[1:0] !== 2'd0) begin
            errors++;
            $display("FAIL R10: low=%0d expected 0", addr_o[1:0]);
        end
        checks++;
        step(1'b0, 8'h00, 1'b1, 1'b0, "R10");
        step(1'b0, 8'h00, 1'b1, 1'b0, "R10");

        // R1: a second reset returns to zero
        @(negedge clk) rst_n = 1'b0;
        #1 m_act = 1'b0;
        check('0, "R1");
        @(negedge clk) rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b1, 1'b1, "R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule